// File: doc/BRIEF.md
# SDRAM Refresh Request Scheduler

This block tells an SDRAM command sequencer when a refresh is owed. It divides the system clock down to tenths of a microsecond and counts those tenths up to an average refresh interval. A 2-bit code selects an interval of 3.9 µs shifted left by the code, so the choices are 3.9, 7.8, 15.6 or 31.2 µs. Each expired interval adds one refresh to a backlog counter. Each refresh that the sequencer acknowledges takes one away.

While refreshes are owed, the block raises a request. In the normal case the request gives way to data traffic. If the backlog grows too deep, the block marks the request urgent. An urgent request is raised even while the bus is busy, so that the sequencer runs the refresh ahead of data accesses. A sticky flag records that the backlog reached the urgent threshold. Software clears the flag by writing 0.

A priority-mode input selects the policy: always yield, escalate on backlog, or always force. Clearing the enable input stops all request generation and drops the backlog.

Top module: `refresh_sched`

## Requirements
- R1: With `enable` high and `cyclesPerUs` ≥ 10, an interval expires after each `39 << intervalCode` tenth-microsecond steps. A tenth step occurs on every clock where an accumulator, after adding 10, reaches `cyclesPerUs`; the accumulator then subtracts `cyclesPerUs`. Each expiry adds one to `pendingCount` on that clock edge.
- R2: While `enable` is low, `refreshReq` and `refreshUrgent` are 0 at once. At the next edge, `pendingCount`, the interval counters and the urgent state clear, and `backlogFlag` keeps its value.
- R3: `pendingCount` never exceeds 8. An expiry at 8 leaves it at 8.
- R4: A `refreshAck` while `pendingCount` > 0 lowers it by one. A `refreshAck` at 0 is ignored. An expiry and an accepted acknowledge on the same edge leave `pendingCount` unchanged.
- R5: In priority mode 00 (yield), `refreshUrgent` stays 0 and `refreshReq` = (`pendingCount` > 0) and not `busBusy`.
- R6: In priority modes 01 and 11 (escalate), the urgent state sets on the edge where `pendingCount` becomes ≥ 4. It clears on the edge where `pendingCount` becomes ≤ 1 and holds in between. While urgent, `refreshUrgent` is 1 and `refreshReq` is 1 regardless of `busBusy`.
- R7: In priority mode 10 (force), `refreshUrgent` and `refreshReq` are 1 whenever `pendingCount` > 0, regardless of `busBusy`.
- R8: `backlogFlag` sets on the edge where `pendingCount` rises from below 4 to 4 or more, in every priority mode. It then stays set until software clears it.
- R9: A write with `statusWrEn` = 1 and `statusWrData` = 0 clears `backlogFlag` at the next edge. A write of 1 has no effect. A hardware set on the same edge wins over a clear.
- R10: After reset, `refreshReq`, `refreshUrgent`, `pendingCount` and `backlogFlag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Scheduler enable; low stops and clears the backlog |
| cyclesPerUs | input | CPU_W | System clocks per microsecond (≥ 10) |
| intervalCode | input | CODE_W | Refresh interval select: 3.9 µs << code |
| prioMode | input | 2 | 00 yield, 01/11 escalate on backlog, 10 always force |
| refreshAck | input | 1 | Sequencer has completed one refresh |
| busBusy | input | 1 | Data traffic is using the memory bus |
| statusWrEn | input | 1 | Software write strobe for the backlog flag |
| statusWrData | input | 1 | Written value; 0 clears the flag |
| refreshReq | output | 1 | A refresh is requested now |
| refreshUrgent | output | 1 | The request has priority over data accesses |
| pendingCount | output | PEND_W | Number of owed refreshes |
| backlogFlag | output | 1 | Sticky record that the backlog reached the threshold |

## Verification
The request and urgent outputs follow `enable`, `busBusy` and the priority mode in the same cycle. The backlog count, the urgent state and the flag all move on the same edge as the expiry or acknowledge that causes them. The flag clear lands one edge after the write.

The bench drives inputs on the falling edge and counts rising edges exactly. With 10 clocks per microsecond, the Nth enabled edge carries the Nth tenth step, so a 39-step interval first lands on edge 39. With 25 clocks per microsecond, it lands on edge 98. Each check samples on the falling edge just before and just after the expected edge, and urgent, acknowledge and flag checks are placed at edges far from the next expiry.

// File: rtl/refresh_sched_pkg.sv
package refresh_sched_pkg;

  // Strobes handed from the timing control to the backlog datapath.
  typedef struct packed {
    logic intervalTick;  // one average refresh interval has elapsed
    logic ackPulse;      // sequencer reports a finished refresh
    logic swClear;       // software wrote 0 to the backlog flag
    logic flush;         // scheduler disabled: drop all state
  } sched_strobe_t;

  typedef enum logic [1:0] {
    MODE_YIELD    = 2'b00,
    MODE_ESCALATE = 2'b01,
    MODE_FORCE    = 2'b10,
    MODE_ESC_ALT  = 2'b11
  } prio_mode_e;

endpackage

// File: rtl/refresh_sched_ctrl.sv
module refresh_sched_ctrl
  import refresh_sched_pkg::*;
#(
  parameter int CPU_W       = 8,
  parameter int CODE_W      = 2,
  parameter int BASE_TENTHS = 39
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CPU_W-1:0]  cyclesPerUs,
  input  logic [CODE_W-1:0] intervalCode,
  input  logic              refreshAck,
  input  logic              statusWrEn,
  input  logic              statusWrData,
  output sched_strobe_t     strobes
);

  localparam int ACC_W   = CPU_W + 1;
  localparam int LONGEST = BASE_TENTHS << ((1 << CODE_W) - 1);
  localparam int CNT_W   = $clog2(LONGEST + 1);

  logic [ACC_W-1:0] accQ;
  logic [ACC_W-1:0] accSum;
  logic [ACC_W-1:0] accNext;
  logic             tenthTick;

  logic [CNT_W-1:0] tenthCntQ;
  logic [CNT_W-1:0] tenthCntNext;
  logic [CNT_W-1:0] lastIdx;
  logic             intervalEnd;

  // Fractional divider: 10 tenths of a microsecond per cyclesPerUs clocks.
  always_comb begin
    accSum    = accQ + ACC_W'(10);
    tenthTick = enable && (accSum >= {1'b0, cyclesPerUs});
    accNext   = tenthTick ? (accSum - {1'b0, cyclesPerUs}) : accSum;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)       accQ <= '0;
    else if (!enable) accQ <= '0;
    else             accQ <= accNext;
  end

  // Interval counter over tenth steps; end index chosen by the code.
  always_comb begin
    lastIdx      = (CNT_W'(BASE_TENTHS) << intervalCode) - CNT_W'(1);
    intervalEnd  = tenthTick && (tenthCntQ >= lastIdx);
    tenthCntNext = tenthCntQ;
    if (tenthTick) begin
      tenthCntNext = intervalEnd ? '0 : tenthCntQ + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        tenthCntQ <= '0;
    else if (!enable) tenthCntQ <= '0;
    else              tenthCntQ <= tenthCntNext;
  end

  always_comb begin
    strobes.intervalTick = intervalEnd;
    strobes.ackPulse     = enable && refreshAck;
    strobes.swClear      = statusWrEn && !statusWrData;
    strobes.flush        = !enable;
  end

endmodule

// File: rtl/refresh_sched_dp.sv
module refresh_sched_dp
  import refresh_sched_pkg::*;
#(
  parameter int PEND_MAX = 8,
  parameter int THRESH   = 4,
  parameter int RELEASE  = 1,
  parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [1:0]        prioMode,
  input  logic              busBusy,
  input  sched_strobe_t     strobes,
  output logic              refreshReq,
  output logic              refreshUrgent,
  output logic [PEND_W-1:0] pendingCount,
  output logic              backlogFlag
);

  logic [PEND_W-1:0] pendQ;
  logic [PEND_W-1:0] pendNext;
  logic              ackOk;
  logic              urgentQ;
  logic              urgentNext;
  logic              flagQ;
  logic              flagNext;
  logic              flagSet;
  prio_mode_e        modeSel;

  assign modeSel = prio_mode_e'(prioMode);

  // Backlog count: saturating, tick and acknowledge cancel.
  always_comb begin
    ackOk    = strobes.ackPulse && (pendQ != '0);
    pendNext = pendQ;
    if (strobes.flush) begin
      pendNext = '0;
    end else if (strobes.intervalTick && ackOk) begin
      pendNext = pendQ;
    end else if (strobes.intervalTick) begin
      if (pendQ != PEND_W'(PEND_MAX)) pendNext = pendQ + PEND_W'(1);
    end else if (ackOk) begin
      pendNext = pendQ - PEND_W'(1);
    end
  end

  // Urgent state with hysteresis between threshold and release level.
  always_comb begin
    urgentNext = urgentQ;
    if (strobes.flush)                         urgentNext = 1'b0;
    else if (pendNext >= PEND_W'(THRESH))      urgentNext = 1'b1;
    else if (pendNext <= PEND_W'(RELEASE))     urgentNext = 1'b0;
  end

  // Sticky flag: hardware set beats a software clear.
  always_comb begin
    flagSet  = (pendNext >= PEND_W'(THRESH)) && (pendQ < PEND_W'(THRESH));
    flagNext = flagQ;
    if (flagSet)              flagNext = 1'b1;
    else if (strobes.swClear) flagNext = 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendQ   <= '0;
      urgentQ <= 1'b0;
      flagQ   <= 1'b0;
    end else begin
      pendQ   <= pendNext;
      urgentQ <= urgentNext;
      flagQ   <= flagNext;
    end
  end

  logic owed;
  logic urgentNow;

  always_comb begin
    owed = enable && (pendQ != '0);
    unique case (modeSel)
      MODE_YIELD:    urgentNow = 1'b0;
      MODE_FORCE:    urgentNow = owed;
      MODE_ESCALATE,
      MODE_ESC_ALT:  urgentNow = owed && urgentQ;
      default:       urgentNow = 1'b0;
    endcase
    refreshUrgent = urgentNow;
    refreshReq    = owed && (!busBusy || urgentNow);
    pendingCount  = pendQ;
    backlogFlag   = flagQ;
  end

endmodule

// File: rtl/refresh_sched.sv
module refresh_sched
  import refresh_sched_pkg::*;
#(
  parameter int CPU_W       = 8,
  parameter int CODE_W      = 2,
  parameter int BASE_TENTHS = 39,
  parameter int PEND_MAX    = 8,
  parameter int THRESH      = 4,
  parameter int RELEASE     = 1,
  localparam int PEND_W     = $clog2(PEND_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic [CPU_W-1:0]  cyclesPerUs,
  input  logic [CODE_W-1:0] intervalCode,
  input  logic [1:0]        prioMode,
  input  logic              refreshAck,
  input  logic              busBusy,
  input  logic              statusWrEn,
  input  logic              statusWrData,
  output logic              refreshReq,
  output logic              refreshUrgent,
  output logic [PEND_W-1:0] pendingCount,
  output logic              backlogFlag
);

  sched_strobe_t strobes;

  refresh_sched_ctrl #(
    .CPU_W      (CPU_W),
    .CODE_W     (CODE_W),
    .BASE_TENTHS(BASE_TENTHS)
  ) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .enable      (enable),
    .cyclesPerUs (cyclesPerUs),
    .intervalCode(intervalCode),
    .refreshAck  (refreshAck),
    .statusWrEn  (statusWrEn),
    .statusWrData(statusWrData),
    .strobes     (strobes)
  );

  refresh_sched_dp #(
    .PEND_MAX(PEND_MAX),
    .THRESH  (THRESH),
    .RELEASE (RELEASE),
    .PEND_W  (PEND_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .prioMode     (prioMode),
    .busBusy      (busBusy),
    .strobes      (strobes),
    .refreshReq   (refreshReq),
    .refreshUrgent(refreshUrgent),
    .pendingCount (pendingCount),
    .backlogFlag  (backlogFlag)
  );

endmodule

// File: rtl/refresh_sched_chk.sv
module refresh_sched_chk #(
  parameter int PEND_MAX = 8,
  parameter int THRESH   = 4,
  parameter int PEND_W   = $clog2(PEND_MAX + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              enable,
  input logic              busBusy,
  input logic              statusWrEn,
  input logic              statusWrData,
  input logic              refreshReq,
  input logic              refreshUrgent,
  input logic [PEND_W-1:0] pendingCount,
  input logic              backlogFlag
);

  p_pend_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    pendingCount <= PEND_W'(PEND_MAX));

  p_off_no_req_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |-> (!refreshReq && !refreshUrgent));

  p_off_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (pendingCount == '0));

  p_step_r4: assert property (@(posedge clk) disable iff (!rstN)
    (enable && $past(enable)) |->
      (({1'b0, pendingCount} <= {1'b0, $past(pendingCount)} + 1'b1) &&
       ({1'b0, pendingCount} + 1'b1 >= {1'b0, $past(pendingCount)})));

  p_yield_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busBusy && !refreshUrgent) |-> !refreshReq);

  p_urgent_req_r6: assert property (@(posedge clk) disable iff (!rstN)
    refreshUrgent |-> (refreshReq && pendingCount != '0));

  p_flag_rise_r8: assert property (@(posedge clk) disable iff (!rstN)
    $rose(backlogFlag) |-> (pendingCount >= PEND_W'(THRESH)));

  p_flag_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(backlogFlag) |-> $past(statusWrEn && !statusWrData));

endmodule

bind refresh_sched refresh_sched_chk #(
  .PEND_MAX(PEND_MAX),
  .THRESH  (THRESH)
) u_chk (.*);

// File: tb/refresh_sched_tb.sv
module refresh_sched_tb;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic [7:0] cyclesPerUs = 8'd10;
  logic [1:0] intervalCode = 2'd0;
  logic [1:0] prioMode = 2'd0;
  logic       refreshAck = 1'b0;
  logic       busBusy = 1'b0;
  logic       statusWrEn = 1'b0;
  logic       statusWrData = 1'b0;
  logic       refreshReq;
  logic       refreshUrgent;
  logic [3:0] pendingCount;
  logic       backlogFlag;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  refresh_sched u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .cyclesPerUs  (cyclesPerUs),
    .intervalCode (intervalCode),
    .prioMode     (prioMode),
    .refreshAck   (refreshAck),
    .busBusy      (busBusy),
    .statusWrEn   (statusWrEn),
    .statusWrData (statusWrData),
    .refreshReq   (refreshReq),
    .refreshUrgent(refreshUrgent),
    .pendingCount (pendingCount),
    .backlogFlag  (backlogFlag)
  );

  task automatic check(input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", what, actual, expected);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // Disable for one edge (clears backlog), clear the flag, then re-enable.
  task automatic restart(input int cpu, input int code, input int mode);
    enable       = 1'b0;
    statusWrEn   = 1'b1;
    statusWrData = 1'b0;
    busBusy      = 1'b0;
    refreshAck   = 1'b0;
    cyclesPerUs  = 8'(cpu);
    intervalCode = 2'(code);
    prioMode     = 2'(mode);
    step(1);
    statusWrEn = 1'b0;
    enable     = 1'b1;
  endtask

  task automatic ack_once();
    refreshAck = 1'b1;
    step(1);
    refreshAck = 1'b0;
  endtask

  task automatic t_reset();
    check("R10 req after reset", refreshReq, 0);
    check("R10 urgent after reset", refreshUrgent, 0);
    check("R10 pending after reset", pendingCount, 0);
    check("R10 flag after reset", backlogFlag, 0);
  endtask

  task automatic t_interval();
    restart(10, 0, 0);
    step(38);
    check("R1 code0 before edge 39", pendingCount, 0);
    step(1);
    check("R1 code0 at edge 39", pendingCount, 1);
    restart(10, 2, 0);
    step(155);
    check("R1 code2 before edge 156", pendingCount, 0);
    step(1);
    check("R1 code2 at edge 156", pendingCount, 1);
  endtask

  task automatic t_fraction();
    restart(25, 0, 0);
    step(97);
    check("R1 fractional before edge 98", pendingCount, 0);
    step(1);
    check("R1 fractional at edge 98", pendingCount, 1);
  endtask

  task automatic t_yield();
    restart(10, 0, 0);
    check("R5 no request with empty backlog", refreshReq, 0);
    step(39);
    busBusy = 1'b1;
    #1;
    check("R5 request yields to busy bus", refreshReq, 0);
    busBusy = 1'b0;
    #1;
    check("R5 request on idle bus", refreshReq, 1);
    check("R5 not urgent in yield mode", refreshUrgent, 0);
  endtask

  task automatic t_ack();
    restart(10, 0, 0);
    ack_once();
    check("R4 ack at zero ignored", pendingCount, 0);
    step(38);
    check("R4 first tick", pendingCount, 1);
    step(38);
    refreshAck = 1'b1;
    step(1);
    refreshAck = 1'b0;
    check("R4 tick and ack same edge", pendingCount, 1);
    ack_once();
    check("R4 ack decrements", pendingCount, 0);
  endtask

  task automatic t_saturate();
    restart(10, 0, 0);
    step(351);
    check("R3 reaches 8", pendingCount, 8);
    step(39);
    check("R3 holds at 8", pendingCount, 8);
  endtask

  task automatic t_escalate();
    restart(10, 0, 1);
    step(155);
    busBusy = 1'b1;
    #1;
    check("R6 not urgent at 3", refreshUrgent, 0);
    check("R6 normal request yields at 3", refreshReq, 0);
    check("R8 flag clear below threshold", backlogFlag, 0);
    step(1);
    check("R6 pending 4", pendingCount, 4);
    check("R6 urgent at 4", refreshUrgent, 1);
    check("R6 urgent request despite busy", refreshReq, 1);
    check("R8 flag set at 4", backlogFlag, 1);
    ack_once();
    check("R6 urgent held at 3", refreshUrgent, 1);
    ack_once();
    check("R6 urgent held at 2", refreshUrgent, 1);
    ack_once();
    check("R6 urgent released at 1", refreshUrgent, 0);
    check("R6 request yields after release", refreshReq, 0);
    check("R8 flag sticky after release", backlogFlag, 1);
    statusWrEn   = 1'b1;
    statusWrData = 1'b1;
    step(1);
    check("R9 write 1 keeps flag", backlogFlag, 1);
    statusWrData = 1'b0;
    step(1);
    statusWrEn = 1'b0;
    check("R9 write 0 clears flag", backlogFlag, 0);
    busBusy = 1'b0;
  endtask

  task automatic t_set_wins();
    restart(10, 0, 3);
    step(155);
    statusWrEn   = 1'b1;
    statusWrData = 1'b0;
    step(1);
    statusWrEn = 1'b0;
    check("R9 set wins over clear", backlogFlag, 1);
    check("R6 mode 11 escalates", refreshUrgent, 1);
  endtask

  task automatic t_force();
    restart(10, 0, 2);
    step(39);
    busBusy = 1'b1;
    #1;
    check("R7 force urgent at 1", refreshUrgent, 1);
    check("R7 force request despite busy", refreshReq, 1);
    busBusy = 1'b0;
  endtask

  task automatic t_yield_backlog_and_disable();
    restart(10, 0, 0);
    step(156);
    check("R8 flag set in yield mode", backlogFlag, 1);
    check("R5 yield mode never urgent", refreshUrgent, 0);
    enable = 1'b0;
    #1;
    check("R2 request drops with enable", refreshReq, 0);
    step(1);
    check("R2 backlog cleared", pendingCount, 0);
    check("R2 flag kept while disabled", backlogFlag, 1);
    step(200);
    check("R2 no ticks while disabled", pendingCount, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(3);
    rstN = 1'b1;
    step(1);
    t_reset();
    t_interval();
    t_fraction();
    t_yield();
    t_ack();
    t_saturate();
    t_escalate();
    t_set_wins();
    t_force();
    t_yield_backlog_and_disable();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule